// File: doc/BRIEF.md
# Memory Access Fault Detector

This block sits beside the data memory in the memory stage of a pipelined processor. It judges every load or store in the cycle the access is presented. The checks are an alignment check driven by the access size, a permission check on the hit and writable flags returned by an external translation buffer, and a programmable address watchpoint. When any check fails, the block raises a fault and reports one exception code. For a store, it also blocks the write into the data memory in that same cycle.

When several checks fail on one access, a fixed order picks the code that is reported. The virtual address of a faulting access is captured into a bad-address register on the following clock edge. Exception handler software can read it there to locate or emulate the access. The register keeps its value until the next fault.

Top module: `mem_fault_detect`

## Requirements
- R1: A byte access (size code 0) never raises an alignment fault, at any address.
- R2: A halfword access (size code 1) with address bit 0 set raises an alignment fault: code 4 for a load, code 5 for a store.
- R3: A word access (size code 2, and size code 3, which is treated as a word) with either of address bits 1:0 set raises an alignment fault: code 4 for a load, code 5 for a store.
- R4: An aligned access with the translation hit flag low faults with code 2 for a load and code 3 for a store.
- R5: A store that hits a page whose writable flag is low faults with code 1. A load to such a page raises no permission fault.
- R6: A watch fault (code 23) requires three things. Address bits above bit 2 must equal watch_lo bits above bit 2, except bits 3 to 3+WMASK_W-1 whose watch_hi bit in the same position is 1. For a load, watch_lo bit 1 (read enable) must be set; for a store, watch_lo bit 0 (write enable) must be set.
- R7: When several conditions hold at once, the reported code follows this order: alignment first, then translation miss, then read-only store, then watch.
- R8: wr_block is high exactly when a valid store faults, in the same cycle as the access.
- R9: bad_vaddr takes the access address on the clock edge that ends a faulting access. It holds its value on every other edge.
- R10: With rst_n low at a clock edge, bad_vaddr clears to 0. When acc_valid is low, fault, fault_code and wr_block are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_vaddr | input | ADDR_W | Virtual address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_store | input | 1 | 1 for store, 0 for load |
| tlb_hit | input | 1 | Translation found a mapping |
| tlb_writable | input | 1 | Mapped page permits writes |
| watch_lo | input | ADDR_W | Watch address in bits above 2, read enable in bit 1, write enable in bit 0 |
| watch_hi | input | ADDR_W | Compare mask for address bits 3 to 3+WMASK_W-1 |
| fault | output | 1 | Access faults this cycle |
| fault_code | output | 5 | Exception code, 0 when no fault |
| wr_block | output | 1 | Suppress the data memory write |
| bad_vaddr | output | ADDR_W | Address of the last faulting access |

## Verification
The bench builds the block with ADDR_W=32 and WMASK_W=9. That size reaches full-width watch comparisons and lets the mask ignore low compare bits 3 and 4, so a masked match and an unmasked miss can be shown on the same pair of addresses. Vectors cover every access size against both alignment positions, both directions, read-only and unmapped pages, and the watch enables. Overlapping-fault cases confirm the priority order. Directed steps check that bad_vaddr holds through idle cycles and clears on a reset taken mid-run.

// File: rtl/mfd_pkg.sv
// Shared encodings for the memory access fault detector.
// Assumes exception code values fixed by the processor's cause register.
package mfd_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRES = 2'd3
    } acc_size_e;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;
    localparam logic [CODE_W-1:0] CODE_RO_WRITE = 5'd1;
    localparam logic [CODE_W-1:0] CODE_MISS_LD  = 5'd2;
    localparam logic [CODE_W-1:0] CODE_MISS_ST  = 5'd3;
    localparam logic [CODE_W-1:0] CODE_ALIGN_LD = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ALIGN_ST = 5'd5;
    localparam logic [CODE_W-1:0] CODE_WATCH    = 5'd23;
endpackage

// File: rtl/mfd_align_chk.sv
// Alignment check: flags a halfword with bit 0 set or a word with bits 1:0 set.
// Assumes size code 3 is handled as a word; bytes are always aligned.
module mfd_align_chk
    import mfd_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       misalign
);
    // Decide misalignment from the size class and low address bits.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = addr_lo[0];
            default: misalign = |addr_lo;
        endcase
    end
endmodule

// File: rtl/mfd_watch_chk.sv
// Watchpoint compare over address bits above bit 2 with a per-bit ignore mask.
// Assumes WMASK_W <= ADDR_W-3; mask bit i covers address bit 3+i.
module mfd_watch_chk #(
    parameter int ADDR_W  = 32,
    parameter int WMASK_W = 9
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] watch_lo,
    input  logic [ADDR_W-1:0] watch_hi,
    output logic              hit
);
    localparam int CMP_W = ADDR_W - 3;

    logic [CMP_W-1:0] bit_ok;
    logic             dir_en;
    logic             unused_wbits;

    // One compare cell per address bit; masked cells always agree.
    for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
        if (i < WMASK_W) begin : g_maskable
            assign bit_ok[i] = watch_hi[3+i] | (vaddr[3+i] == watch_lo[3+i]);
        end else begin : g_fixed
            assign bit_ok[i] = (vaddr[3+i] == watch_lo[3+i]);
        end
    end

    // Pick the enable that matches the access direction.
    always_comb dir_en = is_store ? watch_lo[0] : watch_lo[1];

    // Combine enable and full compare.
    always_comb hit = dir_en & (&bit_ok);

    // Bits that carry no meaning for the compare.
    always_comb unused_wbits = ^{vaddr[2:0], watch_lo[2], watch_hi[2:0],
                                 watch_hi[ADDR_W-1:3+WMASK_W]};
endmodule

// File: rtl/mfd_prio_enc.sv
// Fixed-priority fault encoder: alignment, then miss, then read-only store, then watch.
// Assumes the condition inputs are already qualified only by address and flags.
module mfd_prio_enc
    import mfd_pkg::*;
(
    input  logic              valid,
    input  logic              is_store,
    input  logic              misalign,
    input  logic              tlb_miss,
    input  logic              ro_store,
    input  logic              watch_hit,
    output logic              fault,
    output logic [CODE_W-1:0] code
);
    // Select the single highest-ranked condition and its code.
    always_comb begin
        fault = 1'b1;
        code  = CODE_NONE;
        if (!valid) begin
            fault = 1'b0;
        end else if (misalign) begin
            code = is_store ? CODE_ALIGN_ST : CODE_ALIGN_LD;
        end else if (tlb_miss) begin
            code = is_store ? CODE_MISS_ST : CODE_MISS_LD;
        end else if (ro_store) begin
            code = CODE_RO_WRITE;
        end else if (watch_hit) begin
            code = CODE_WATCH;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/mem_fault_detect.sv
// Memory-stage fault detector: judges each load/store in its own cycle,
// blocks faulting stores and records the faulting address.
// Assumes translation flags and watch registers are valid with acc_valid.
module mem_fault_detect
    import mfd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WMASK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_vaddr,
    input  logic [1:0]        acc_size,
    input  logic              acc_store,
    input  logic              tlb_hit,
    input  logic              tlb_writable,
    input  logic [ADDR_W-1:0] watch_lo,
    input  logic [ADDR_W-1:0] watch_hi,
    output logic              fault,
    output logic [4:0]        fault_code,
    output logic              wr_block,
    output logic [ADDR_W-1:0] bad_vaddr
);
    logic misalign;
    logic watch_hit;
    logic tlb_miss;
    logic ro_store;

    mfd_align_chk u_align (
        .addr_lo  (acc_vaddr[1:0]),
        .size     (acc_size),
        .misalign (misalign)
    );

    mfd_watch_chk #(
        .ADDR_W  (ADDR_W),
        .WMASK_W (WMASK_W)
    ) u_watch (
        .vaddr    (acc_vaddr),
        .is_store (acc_store),
        .watch_lo (watch_lo),
        .watch_hi (watch_hi),
        .hit      (watch_hit)
    );

    // Permission conditions from the translation flags.
    always_comb begin
        tlb_miss = ~tlb_hit;
        ro_store = acc_store & tlb_hit & ~tlb_writable;
    end

    mfd_prio_enc u_prio (
        .valid     (acc_valid),
        .is_store  (acc_store),
        .misalign  (misalign),
        .tlb_miss  (tlb_miss),
        .ro_store  (ro_store),
        .watch_hit (watch_hit),
        .fault     (fault),
        .code      (fault_code)
    );

    // Block the write of any store that faults.
    always_comb wr_block = fault & acc_store;

    // Capture the address of a faulting access for the handler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_vaddr <= '0;
        end else if (fault) begin
            bad_vaddr <= acc_vaddr;
        end
    end
endmodule

// File: rtl/mem_fault_detect_chk.sv
// Property checker for mem_fault_detect, attached by bind.
module mem_fault_detect_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_vaddr,
    input logic [1:0]        acc_size,
    input logic              acc_store,
    input logic              fault,
    input logic [4:0]        fault_code,
    input logic              wr_block,
    input logic [ADDR_W-1:0] bad_vaddr
);
    a_r8_block_only_faulting_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> (fault && acc_store));
    a_r8_faulting_store_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && acc_store) |-> wr_block);
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (bad_vaddr == $past(acc_vaddr)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> $stable(bad_vaddr));
    a_r1_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size == 2'd0) |-> !(fault_code == 5'd4 || fault_code == 5'd5));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!fault && !wr_block && fault_code == 5'd0));
    a_r5_ro_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 5'd1) |-> acc_store);
    a_r4_miss_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 5'd2) |-> !acc_store);
endmodule

bind mem_fault_detect mem_fault_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_vaddr  (acc_vaddr),
    .acc_size   (acc_size),
    .acc_store  (acc_store),
    .fault      (fault),
    .fault_code (fault_code),
    .wr_block   (wr_block),
    .bad_vaddr  (bad_vaddr)
);

// File: tb/mem_fault_detect_tb.sv
module mem_fault_detect_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_vaddr = '0;
    logic [1:0]    acc_size = '0;
    logic          acc_store = 1'b0;
    logic          tlb_hit = 1'b0;
    logic          tlb_writable = 1'b0;
    logic [AW-1:0] watch_lo = '0;
    logic [AW-1:0] watch_hi = '0;
    logic          fault;
    logic [4:0]    fault_code;
    logic          wr_block;
    logic [AW-1:0] bad_vaddr;

    int n_chk = 0;
    int n_fail = 0;
    logic [AW-1:0] exp_bva = '0;

    always #4 clk = ~clk;

    mem_fault_detect #(.ADDR_W(AW), .WMASK_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .acc_size(acc_size), .acc_store(acc_store), .tlb_hit(tlb_hit),
        .tlb_writable(tlb_writable), .watch_lo(watch_lo), .watch_hi(watch_hi),
        .fault(fault), .fault_code(fault_code), .wr_block(wr_block),
        .bad_vaddr(bad_vaddr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        st;
        logic        hit;
        logic        wrt;
        logic [31:0] wlo;
        logic [31:0] whi;
        logic        ef;
        logic [4:0]  ec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h1003, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 5'd0,  4'd1},  // R1 byte load odd
        '{32'h2001, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 5'd0,  4'd1},  // R1 byte store odd
        '{32'h1001, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0, 1'b1, 5'd4,  4'd2},  // R2 half load
        '{32'h1003, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 1'b1, 5'd5,  4'd2},  // R2 half store
        '{32'h1002, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 5'd0,  4'd2},  // R2 aligned half
        '{32'h1002, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0, 1'b1, 5'd4,  4'd3},  // R3 word load
        '{32'h1001, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 1'b1, 5'd5,  4'd3},  // R3 word store
        '{32'h1004, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 5'd0,  4'd3},  // R3 aligned word
        '{32'h1004, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 5'd2,  4'd4},  // R4 load miss
        '{32'h1006, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 1'b1, 5'd3,  4'd4},  // R4 store miss
        '{32'h1008, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 5'd1,  4'd5},  // R5 store read-only
        '{32'h1008, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 5'd0,  4'd5},  // R5 load read-only
        '{32'h4008, 2'd2, 1'b0, 1'b1, 1'b1, 32'h400A, 32'h0, 1'b1, 5'd23, 4'd6}, // R6 read watch
        '{32'h4008, 2'd2, 1'b1, 1'b1, 1'b1, 32'h400A, 32'h0, 1'b0, 5'd0,  4'd6}, // R6 write not enabled
        '{32'h400F, 2'd0, 1'b1, 1'b1, 1'b1, 32'h4009, 32'h0, 1'b1, 5'd23, 4'd6}, // R6 byte in doubleword
        '{32'h4010, 2'd2, 1'b0, 1'b1, 1'b1, 32'h400A, 32'h0, 1'b0, 5'd0,  4'd6}, // R6 next doubleword
        '{32'h4010, 2'd2, 1'b0, 1'b1, 1'b1, 32'h400A, 32'h18, 1'b1, 5'd23, 4'd6}, // R6 masked
        '{32'h4009, 2'd2, 1'b1, 1'b0, 1'b0, 32'h4009, 32'h0, 1'b1, 5'd5,  4'd7}, // R7 align first
        '{32'h4008, 2'd2, 1'b1, 1'b0, 1'b0, 32'h4009, 32'h0, 1'b1, 5'd3,  4'd7}, // R7 miss over ro
        '{32'h4008, 2'd2, 1'b1, 1'b1, 1'b0, 32'h4009, 32'h0, 1'b1, 5'd1,  4'd7}, // R7 ro over watch
        '{32'h4008, 2'd2, 1'b0, 1'b1, 1'b0, 32'h400A, 32'h0, 1'b1, 5'd23, 4'd7}  // R7 load ro watch
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (2) @(posedge clk);
        #1;
        chk(bad_vaddr == '0, "R10 reset bad_vaddr", bad_vaddr, 0);
        chk(!fault && !wr_block, "R10 reset fault", {fault, wr_block}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_valid    = 1'b1;
            acc_vaddr    = VECS[i].addr;
            acc_size     = VECS[i].size;
            acc_store    = VECS[i].st;
            tlb_hit      = VECS[i].hit;
            tlb_writable = VECS[i].wrt;
            watch_lo     = VECS[i].wlo;
            watch_hi     = VECS[i].whi;
            #1;
            chk(fault == VECS[i].ef, $sformatf("R%0d fault vec%0d", VECS[i].req, i), fault, VECS[i].ef);
            chk(fault_code == VECS[i].ec, $sformatf("R%0d code vec%0d", VECS[i].req, i), fault_code, VECS[i].ec);
            // R8: write blocked only for faulting stores
            chk(wr_block == (VECS[i].ef & VECS[i].st), $sformatf("R8 wr_block vec%0d", i),
                wr_block, VECS[i].ef & VECS[i].st);
            @(posedge clk);
            #1;
            if (VECS[i].ef) exp_bva = VECS[i].addr;
            chk(bad_vaddr == exp_bva, $sformatf("R9 bad_vaddr vec%0d", i), bad_vaddr, exp_bva);
        end

        // R10: idle cycle with a misaligned store address shows nothing
        @(negedge clk);
        acc_valid = 1'b0;
        acc_vaddr = 32'h7777;
        acc_size  = 2'd2;
        acc_store = 1'b1;
        tlb_hit   = 1'b0;
        #1;
        chk(!fault && fault_code == 5'd0, "R10 idle fault", {fault, fault_code}, 0);
        chk(!wr_block, "R10 idle wr_block", wr_block, 0);
        @(posedge clk);
        #1;
        chk(bad_vaddr == exp_bva, "R9 hold on idle", bad_vaddr, exp_bva);

        // R10: reset taken mid-run clears the captured address
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(bad_vaddr == '0, "R10 mid-run reset", bad_vaddr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule